// File: doc/BRIEF.md
# Registered Sixteen-Bit Multifunction ALU

This block is a small arithmetic logic unit built as a three-register datapath. On every rising clock edge it loads two 16-bit operands into their own registers. During the following cycle a 3-bit function code selects one of eight results through a single multiplexer. That result is loaded into a 16-bit result register, together with a carry flag, on the next rising edge.

The functions are:
- forward the first operand unchanged
- sum
- difference, computed on one shared carry-chain adder
- bitwise AND
- bitwise OR
- zero-filling left shift by 0 to 3 places
- low half of a 16x16 array product
- a constant zero

Arithmetic functions report a carry. All other functions clear the carry.

The datapath never stalls. It accepts a new operand pair and a new function code on every cycle. There is no back-pressure: a result register that is not read is overwritten on the next edge.

The function code is not registered. Software or a sequencer presents the operands in one cycle and the function code in the next. The answer then appears one edge later.

Top module: `alu16_reg`

## Requirements
- R1: While `rst_n` is low, the operand registers, `res_out` and `cout_out` are held at zero, whatever `a_in`, `b_in` and `op_in` carry.
- R2: The value loaded into `res_out`/`cout_out` at an edge is computed from the operands loaded at the previous edge and the `op_in` value present at the current edge. Operands presented at the current edge do not affect it.
- R3: Code 3'b001 loads the registered A unchanged and clears the carry.
- R4: Code 3'b010 loads (A + B) mod 2^16, with `cout_out` equal to bit 16 of the full sum. For example, 0x7FFF + 0x0001 gives 0x8000 with carry 0, and 0xFFFF + 0x0001 gives 0x0000 with carry 1.
- R5: Code 3'b011 loads (A - B) mod 2^16, with `cout_out` = 1 exactly when A >= B (no borrow).
- R6: Code 3'b110 loads A AND B, and code 3'b111 loads A OR B.
- R7: Code 3'b100 loads A shifted left by B[1:0] places with zeros shifted in. B[15:2] has no effect.
- R8: Code 3'b101 loads the low 16 bits of the unsigned 32-bit product A * B.
- R9: Code 3'b000 loads 0x0000.
- R10: For every code other than 3'b010 and 3'b011, `cout_out` is loaded as 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock; all registers load on the rising edge |
| rst_n | input | 1 | Active-low asynchronous reset |
| a_in | input | 16 | Operand A, loaded every cycle |
| b_in | input | 16 | Operand B, loaded every cycle |
| op_in | input | 3 | Function code applied to the registered operands |
| res_out | output | 16 | Registered result |
| cout_out | output | 1 | Registered carry / no-borrow flag |

## Verification
The bound checker watches several rules on every clocked cycle:
- the result stays at zero while reset holds;
- the forward, AND and zero codes hold their values;
- a zero shift amount gives back A;
- the no-borrow flag follows the comparison of the registered operands;
- the carry is cleared for every non-arithmetic code.

Other behaviours need the bench's behavioural reference model and its scenarios:
- the full values of sum, difference and product, including the all-ones and sign-boundary corners;
- the one-cycle offset between operands and function code;
- the fact that the upper bits of B leave the shift unchanged.

// File: rtl/alu16_pkg.sv
package alu16_pkg;

  localparam int OP_W = 3;

  typedef enum logic [OP_W-1:0] {
    OP_ZERO = 3'b000,
    OP_PASS = 3'b001,
    OP_ADD  = 3'b010,
    OP_SUB  = 3'b011,
    OP_SHL  = 3'b100,
    OP_MUL  = 3'b101,
    OP_AND  = 3'b110,
    OP_OR   = 3'b111
  } alu_op_e;

  // true for the codes that drive the carry flag
  function automatic logic op_is_arith(alu_op_e op);
    return (op == OP_ADD) || (op == OP_SUB);
  endfunction

endpackage

// File: rtl/alu16_addsub.sv
// Ripple carry adder shared between sum and difference.
// Difference = A + ~B + 1; carry out then means "no borrow".
module alu16_addsub #(
  parameter int W = 16
) (
  input  logic [W-1:0] a,
  input  logic [W-1:0] b,
  input  logic         sub,
  output logic [W-1:0] sum,
  output logic         cout
);

  logic [W:0] carry;

  assign carry[0] = sub;

  for (genvar i = 0; i < W; i++) begin : g_bit
    logic bx;
    logic prop;
    assign bx           = b[i] ^ sub;
    assign prop         = a[i] ^ bx;
    assign sum[i]       = prop ^ carry[i];
    assign carry[i + 1] = (a[i] & bx) | (carry[i] & prop);
  end

  assign cout = carry[W];

endmodule

// File: rtl/alu16_shl.sv
// Logarithmic left shifter: stage k moves the word by 2**k places
// when amount bit k is set. Vacated bits fill with zero.
module alu16_shl #(
  parameter int W    = 16,
  parameter int SH_W = 2
) (
  input  logic [W-1:0]    a,
  input  logic [SH_W-1:0] amt,
  output logic [W-1:0]    y
);

  logic [W-1:0] stage [SH_W+1];

  assign stage[0] = a;

  for (genvar k = 0; k < SH_W; k++) begin : g_stage
    localparam int DIST = 1 << k;
    assign stage[k + 1] = amt[k] ? (stage[k] << DIST) : stage[k];
  end

  assign y = stage[SH_W];

endmodule

// File: rtl/alu16_mul_array.sv
// Array multiplier truncated to W bits. Each row adds one shifted
// partial product. Bits at or above W are never formed.
module alu16_mul_array #(
  parameter int W = 16
) (
  input  logic [W-1:0] a,
  input  logic [W-1:0] b,
  output logic [W-1:0] p
);

  logic [W-1:0] acc [W+1];

  assign acc[0] = '0;

  for (genvar i = 0; i < W; i++) begin : g_row
    logic [W-1:0] part;
    assign part       = b[i] ? (a << i) : '0;
    assign acc[i + 1] = acc[i] + part;
  end

  assign p = acc[W];

endmodule

// File: rtl/alu16_reg.sv
// Registered multifunction ALU: operand registers, function units,
// eight-way result select and the result/carry register.
module alu16_reg
  import alu16_pkg::*;
#(
  parameter int W    = 16,
  parameter int SH_W = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [W-1:0]      a_in,
  input  logic [W-1:0]      b_in,
  input  logic [OP_W-1:0]   op_in,
  output logic [W-1:0]      res_out,
  output logic              cout_out
);

  logic [W-1:0] a_q;
  logic [W-1:0] b_q;
  logic [W-1:0] res_q;
  logic         cout_q;

  alu_op_e      op;
  logic         do_sub;
  logic [W-1:0] sum_w;
  logic         carry_w;
  logic [W-1:0] shl_w;
  logic [W-1:0] mul_w;
  logic [W-1:0] res_d;
  logic         cout_d;

  // operand registers
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      a_q <= '0;
      b_q <= '0;
    end else begin
      a_q <= a_in;
      b_q <= b_in;
    end
  end

  assign op     = alu_op_e'(op_in);
  assign do_sub = (op == OP_SUB);

  alu16_addsub #(.W(W)) u_addsub (
    .a    (a_q),
    .b    (b_q),
    .sub  (do_sub),
    .sum  (sum_w),
    .cout (carry_w)
  );

  alu16_shl #(.W(W), .SH_W(SH_W)) u_shl (
    .a   (a_q),
    .amt (b_q[SH_W-1:0]),
    .y   (shl_w)
  );

  alu16_mul_array #(.W(W)) u_mul (
    .a (a_q),
    .b (b_q),
    .p (mul_w)
  );

  // eight-way result select
  always_comb begin
    unique case (op)
      OP_PASS: res_d = a_q;
      OP_ADD,
      OP_SUB:  res_d = sum_w;
      OP_SHL:  res_d = shl_w;
      OP_MUL:  res_d = mul_w;
      OP_AND:  res_d = a_q & b_q;
      OP_OR:   res_d = a_q | b_q;
      default: res_d = '0;
    endcase
  end

  assign cout_d = op_is_arith(op) & carry_w;

  // result register
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      res_q  <= '0;
      cout_q <= 1'b0;
    end else begin
      res_q  <= res_d;
      cout_q <= cout_d;
    end
  end

  assign res_out  = res_q;
  assign cout_out = cout_q;

endmodule

// File: rtl/alu16_reg_chk.sv
module alu16_reg_chk
  import alu16_pkg::*;
#(
  parameter int W = 16
) (
  input logic            clk,
  input logic            rst_n,
  input logic [OP_W-1:0] op_in,
  input logic [W-1:0]    a_q,
  input logic [W-1:0]    b_q,
  input logic [W-1:0]    res_out,
  input logic            cout_out
);

  // R1: a cycle that starts in reset and is still in reset ends with cleared outputs
  p_reset_clear_r1: assert property (@(posedge clk)
    !rst_n |=> (rst_n || (res_out == '0 && !cout_out)));

  // R3
  p_pass_a_r3: assert property (@(posedge clk) disable iff (!rst_n)
    op_in == OP_PASS |=> (res_out == $past(a_q) && !cout_out));

  // R5
  p_no_borrow_r5: assert property (@(posedge clk) disable iff (!rst_n)
    op_in == OP_SUB |=> (cout_out == ($past(a_q) >= $past(b_q))));

  // R6
  p_and_r6: assert property (@(posedge clk) disable iff (!rst_n)
    op_in == OP_AND |=> (res_out == ($past(a_q) & $past(b_q))));

  // R7
  p_shift_zero_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (op_in == OP_SHL && b_q[1:0] == 2'b00) |=> (res_out == $past(a_q)));

  // R9
  p_zero_code_r9: assert property (@(posedge clk) disable iff (!rst_n)
    op_in == OP_ZERO |=> (res_out == '0));

  // R10
  p_flag_clear_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (op_in != OP_ADD && op_in != OP_SUB) |=> !cout_out);

endmodule

bind alu16_reg alu16_reg_chk #(.W(W)) u_chk (
  .clk      (clk),
  .rst_n    (rst_n),
  .op_in    (op_in),
  .a_q      (a_q),
  .b_q      (b_q),
  .res_out  (res_out),
  .cout_out (cout_out)
);

// File: tb/test_alu16_reg.sv
module test_alu16_reg;

  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [15:0] a_in = '0;
  logic [15:0] b_in = '0;
  logic [2:0]  op_in = '0;
  logic [15:0] res_out;
  logic        cout_out;

  int n_chk = 0;
  int n_err = 0;
  bit chk_en = 0;
  bit lat_mode = 0;
  bit done = 0;

  // reference model state
  logic [15:0] ma, mb, e_res;
  logic        e_c;
  string       e_tag, c_tag;

  always #(CLK_PERIOD/2) clk = ~clk;

  alu16_reg i_alu16_reg (
    .clk      (clk),
    .rst_n    (rst_n),
    .a_in     (a_in),
    .b_in     (b_in),
    .op_in    (op_in),
    .res_out  (res_out),
    .cout_out (cout_out)
  );

  function automatic string tag_of(logic [2:0] op);
    case (op)
      3'd1:    return "R3";
      3'd2:    return "R4";
      3'd3:    return "R5";
      3'd4:    return "R7";
      3'd5:    return "R8";
      3'd6,
      3'd7:    return "R6";
      default: return "R9";
    endcase
  endfunction

  // behavioural model, stepped on every rising edge
  always @(posedge clk) begin
    if (!rst_n) begin
      ma = '0; mb = '0; e_res = '0; e_c = 1'b0;
      e_tag = "R1"; c_tag = "R1";
    end else begin
      int unsigned s;
      e_c = 1'b0;
      case (op_in)
        3'd1: e_res = ma;
        3'd2: begin s = ma + mb; e_res = s[15:0]; e_c = s[16]; end
        3'd3: begin s = ma - mb; e_res = s[15:0]; e_c = (ma >= mb); end
        3'd4: e_res = ma << mb[1:0];
        3'd5: begin s = ma * mb; e_res = s[15:0]; end
        3'd6: e_res = ma & mb;
        3'd7: e_res = ma | mb;
        default: e_res = '0;
      endcase
      e_tag = lat_mode ? "R2" : tag_of(op_in);
      c_tag = (op_in == 3'd2 || op_in == 3'd3) ? e_tag : "R10";
      ma = a_in;
      mb = b_in;
    end
  end

  always @(negedge clk) begin
    if (chk_en) begin
      n_chk++;
      if (res_out !== e_res) begin
        n_err++;
        $display("FAIL %s result actual %h expected %h", e_tag, res_out, e_res);
      end
      n_chk++;
      if (cout_out !== e_c) begin
        n_err++;
        $display("FAIL %s carry actual %b expected %b", c_tag, cout_out, e_c);
      end
    end
  end

  // operands in one cycle, function code in the next
  task automatic run(input logic [15:0] a, input logic [15:0] b, input logic [2:0] op);
    @(negedge clk);
    a_in = a; b_in = b; op_in = 3'd0;
    @(negedge clk);
    op_in = op;
  endtask

  initial begin
    // R1: reset ignores busy inputs
    a_in = 16'hA5A5; b_in = 16'h5A5A; op_in = 3'd2;
    @(posedge clk);
    chk_en = 1;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;

    run(16'h7FFF, 16'h0001, 3'd2);   // R4 sign boundary
    run(16'hFFFF, 16'h0001, 3'd2);   // R4 carry
    run(16'h1234, 16'h1234, 3'd3);   // R5 equal
    run(16'h0000, 16'h0001, 3'd3);   // R5 borrow
    run(16'hBEEF, 16'h0000, 3'd1);   // R3
    run(16'hF0F0, 16'hCCCC, 3'd6);   // R6 and
    run(16'hF0F0, 16'hCCCC, 3'd7);   // R6 or
    run(16'h8001, 16'hFFFE, 3'd4);   // R7 upper B bits ignored, shift 2
    run(16'h8001, 16'h0003, 3'd4);   // R7 shift 3
    run(16'hFFFF, 16'hFFFF, 3'd5);   // R8 low half 0x0001
    run(16'h1234, 16'h5678, 3'd0);   // R9

    // R2: operands change in the cycle the code is applied
    @(negedge clk);
    a_in = 16'h1234; b_in = 16'h0F0F; op_in = 3'd0;
    @(negedge clk);
    a_in = 16'hFFFF; b_in = 16'hFFFF; op_in = 3'd1; lat_mode = 1;
    @(negedge clk);
    op_in = 3'd6;
    @(negedge clk);
    lat_mode = 0;

    // random streams over every code
    for (int i = 0; i < 3000; i++) begin
      @(negedge clk);
      a_in = 16'($urandom);
      b_in = 16'($urandom);
      op_in = 3'($urandom);
    end
    @(negedge clk);
    @(negedge clk);
    chk_en = 0;
    done = 1;
    $display("CHECKS %0d ERRORS %0d", n_chk, n_err);
    $finish;
  end

  initial begin
    repeat (50000) @(posedge clk);
    if (!done) begin
      n_err++;
      $display("FAIL watchdog expired actual running expected finished");
      $display("CHECKS %0d ERRORS %0d", n_chk, n_err);
      $finish;
    end
  end

endmodule